// File: doc/BRIEF.md
# GPIO Port Output Data Register with Atomic Set and Clear

This block holds the output data latch of one general-purpose I/O port, 4 to 8 bits wide. Software can change it in three ways. A direct write loads every implemented bit at once. A set write forces high the bits written as one. A clear write forces low the bits written as zero, which is active-low write data. The set and clear paths let one bit change without a read-modify-write sequence, so other agents that touch the same port cannot race it.

The register bus is synchronous and has three locations. The data location reads back the latched output value. The set location reads back the pin levels, taken through a two-flop synchroniser. The clear location always reads as zero. Ports narrower than 8 bits implement only their low bits, and the reserved upper bits are inert.

Top module: `gpio_port_data`

## Requirements
- R1: After reset, `data_o` is all zeros, and a read of the clear location (address 2) returns zero.
- R2: A write to the data location (address 0) loads `wdata_i[PORT_W-1:0]` into the output register on the next rising clock edge.
- R3: A write to the set location (address 1) sets each output bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to the clear location (address 2) clears each output bit written as 0 and leaves each bit written as 1 unchanged.
- R5: A read of the clear location returns all zeros, whatever the register holds.
- R6: A read of the set location returns the pin levels `pin_i` as they were two rising edges earlier, through a two-flop synchroniser.
- R7: Bits at `PORT_W` and above read as zero from every location, and write data in those bits has no effect.
- R8: A read of the data location returns the current latched output value.
- R9: The output register does not change when `wr_en_i` is low or when a write targets the unused address 3. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released in step with the clock. |
| addr_i | input | 2 | Register select: 0 data, 1 set/pin, 2 clear, 3 unused |
| wr_en_i | input | 1 | Write strobe for the selected location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected location (combinational) |
| pin_i | input | PORT_W | Pin levels from the pads |
| data_o | output | PORT_W | Latched output data |

## Verification
Write results show up on `data_o` and on a data-location read one edge after the write is presented. A pin change is seen on a set-location read after the second edge. A clear-location read and any reserved bit are zero in the same cycle. After reset is removed, the internal reset lasts two more edges. The bench runs a behavioural model that is updated on every rising edge, with the same delays counted out. At each falling edge it compares `data_o` and `rdata_o` with that model, so every result is checked in the exact cycle it is due. The bench port is 6 bits wide, so the reserved bits are exercised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    LOC_DATA   = 2'd0,
    LOC_SETPIN = 2'd1,
    LOC_CLR    = 2'd2,
    LOC_NONE   = 2'd3
  } gpio_loc_e;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
  } gpio_wr_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

  a_r1_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage2_q) |-> $past(stage1_q));

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_sync_o
);

  logic [PORT_W-1:0] meta_q;
  logic [PORT_W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign pin_sync_o = sync_q;

  a_r6_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sync_q == $past(meta_q)));

endmodule

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output gpio_wr_t          wr_o
);

  always_comb begin
    wr_o = '0;
    if (wr_en_i) begin
      unique case (gpio_loc_e'(addr_i))
        LOC_DATA:   wr_o.load = 1'b1;
        LOC_SETPIN: wr_o.set  = 1'b1;
        LOC_CLR:    wr_o.clr  = 1'b1;
        default:    wr_o      = '0;
      endcase
    end
  end

  always_comb begin
    a_r9_one_path: assert ($onehot0({wr_o.load, wr_o.set, wr_o.clr}));
  end

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gpio_wr_t          wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] data_o
);

  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    data_d  = data_q;
    data_en = 1'b0;
    if (wr_i.load) begin
      data_d  = wdata_i;
      data_en = 1'b1;
    end else if (wr_i.set) begin
      data_d  = data_q | wdata_i;
      data_en = 1'b1;
    end else if (wr_i.clr) begin
      data_d  = data_q & wdata_i;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign data_o = data_q;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i.load |=> (data_q == $past(wdata_i)));

  a_r3_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i.set |=> (((data_q & $past(wdata_i)) == $past(wdata_i)) &&
                  ((data_q & ~$past(wdata_i)) == ($past(data_q) & ~$past(wdata_i)))));

  a_r4_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i.clr |=> (((data_q & ~$past(wdata_i)) == '0) &&
                  ((data_q & $past(wdata_i)) == ($past(data_q) & $past(wdata_i)))));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i.load || wr_i.set || wr_i.clr) |=> $stable(data_q));

endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] data_o
);

  logic              rst_q_n;
  gpio_wr_t          wr;
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] rd_field;

  gpio_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  gpio_wr_decode u_decode (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wr_o    (wr)
  );

  gpio_pin_sync #(.PORT_W(PORT_W)) u_pin_sync (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .pin_i      (pin_i),
    .pin_sync_o (pin_sync)
  );

  gpio_out_reg #(.PORT_W(PORT_W)) u_out_reg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_i    (wr),
    .wdata_i (wdata_i[PORT_W-1:0]),
    .data_o  (data_q)
  );

  always_comb begin
    unique case (gpio_loc_e'(addr_i))
      LOC_DATA:   rd_field = data_q;
      LOC_SETPIN: rd_field = pin_sync;
      default:    rd_field = '0;
    endcase
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[PORT_W-1:0] = rd_field;
  end

  assign data_o = data_q;

  a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_i == 2'd2) |-> (rdata_o == 8'h00));

  a_r8_data_readback: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_i == 2'd0) |-> (rdata_o[PORT_W-1:0] == data_o));

  always_comb begin
    if (PORT_W < 8) begin
      a_r7_reserved_zero: assert ((rdata_o >> PORT_W) == 8'h00);
    end
  end

endmodule

// File: tb/gpio_port_data_tb.sv
module gpio_port_data_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;
  localparam int MASK       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   addr;
  logic         wr_en;
  logic [7:0]   wdata;
  logic [7:0]   rdata;
  logic [W-1:0] pin;
  logic [W-1:0] dout;

  int total = 0;
  int bad   = 0;
  string last_tag = "R1";

  int m_data, m_p1, m_p2;
  bit rs1, rs2;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_data #(.PORT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .data_o(dout)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; m_data = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      if (!rs2) begin
        m_data = 0; m_p1 = 0; m_p2 = 0;
      end else begin
        if (wr_en) begin
          case (addr)
            2'd0: m_data = int'(wdata) & MASK;
            2'd1: m_data = (m_data | int'(wdata)) & MASK;
            2'd2: m_data = m_data & int'(wdata) & MASK;
            default: ;
          endcase
        end
        m_p2 = m_p1;
        m_p1 = int'(pin);
      end
      rs2 = rs1;
      rs1 = 1;
    end
  end

  function automatic int exp_rd();
    case (addr)
      2'd0:    return m_data;
      2'd1:    return m_p2;
      default: return 0;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", last_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(int'(dout), m_data, "data_o");
    check(int'(rdata), exp_rd(), "rdata_o");
  endtask

  task automatic op(input logic [1:0] a, input logic we, input logic [7:0] wd,
                    input logic [W-1:0] p, input string tag);
    @(negedge clk);
    compare();
    last_tag = tag;
    addr = a; wr_en = we; wdata = wd; pin = p;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = 2'd2; wr_en = 1'b0; wdata = 8'h00; pin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, clear location reads zero
    op(2'd2, 0, 8'h00, '0, "R1");
    op(2'd2, 0, 8'h00, '0, "R1");
    op(2'd2, 0, 8'h00, '0, "R1");
    op(2'd0, 0, 8'h00, '0, "R1");
    // R2 and R7: load with reserved bits set
    op(2'd0, 1, 8'hFF, '0, "R2_R7");
    op(2'd0, 1, 8'h15, '0, "R2");
    op(2'd0, 0, 8'h00, '0, "R8");
    // R3: set ones, zeros ignored
    op(2'd1, 1, 8'h22, '0, "R3");
    op(2'd1, 1, 8'h00, '0, "R3");
    op(2'd1, 1, 8'hC0, '0, "R3_R7");
    op(2'd0, 0, 8'h00, '0, "R8");
    // R4: clear on zeros, ones ignored
    op(2'd2, 1, 8'hFE, '0, "R4");
    op(2'd2, 1, 8'hFF, '0, "R4");
    op(2'd2, 1, 8'h3F, '0, "R4_R7");
    op(2'd0, 0, 8'h00, '0, "R8");
    op(2'd2, 1, 8'hC0, '0, "R4");
    // R5: clear reads zero with register nonzero
    op(2'd0, 1, 8'h2D, '0, "R2");
    op(2'd2, 0, 8'h00, '0, "R5");
    op(2'd2, 0, 8'h00, 6'h3F, "R5");
    // R6: pin path latency
    op(2'd1, 0, 8'h00, 6'h2A, "R6");
    op(2'd1, 0, 8'h00, 6'h2A, "R6");
    op(2'd1, 0, 8'h00, 6'h15, "R6");
    op(2'd1, 0, 8'h00, 6'h15, "R6");
    op(2'd1, 0, 8'h00, 6'h15, "R6");
    // R9: no write without strobe, address 3 inert
    op(2'd0, 0, 8'h00, '0, "R9");
    op(2'd2, 0, 8'h00, '0, "R9");
    op(2'd3, 1, 8'h00, '0, "R9");
    op(2'd3, 1, 8'hFF, '0, "R9");
    op(2'd0, 0, 8'h00, '0, "R9");
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      op(2'($urandom), 1'($urandom), 8'($urandom), W'($urandom), "R2_R3_R4_R6_R7");
    end
    // R1: reset during operation
    op(2'd0, 1, 8'h3F, '0, "R2");
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    #1;
    last_tag = "R1";
    check(int'(dout), 0, "data_o async reset");
    @(negedge clk) rst_n = 1'b1;
    op(2'd0, 1, 8'h11, '0, "R1");
    op(2'd0, 0, 8'h00, '0, "R1");
    op(2'd0, 0, 8'h00, '0, "R1");
    op(2'd0, 1, 8'h11, '0, "R1");
    op(2'd0, 0, 8'h00, '0, "R2");
    op(2'd0, 0, 8'h00, '0, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule